// File: doc/BRIEF.md
# Miss-Count Guided Victim Selector for a Shared Cache Set

This block decides, for one set of a shared second-level cache, which way to evict when a new block must be filled and whether that new block should be pinned. It holds a small table of block addresses, each with the miss count found by profiling. Before a task starts, the table is written through a load port. Entries must be written with the highest miss count at index 0 and the counts falling as the index rises. The index of an entry is its rank.

On each fill request the block takes the incoming block address and the tag, valid and lock state of every way in the set. It compares all of these addresses against every table entry in parallel. One cycle later it returns the way to evict, a flag saying no way can be evicted, and a lock decision for the incoming block.

Ways are ranked for eviction in this order. An empty way is taken first. A pinned way is never taken. An address the table does not hold is treated as colder than any address it does hold. Among held addresses, the lowest miss count loses. Ties are broken by a free-running pseudo-random register.

Top module: `l2_victim_pick`

## Requirements
- R1: A write on the table port with `tbl_we`=1 stores `tbl_keep`, `tbl_addr` and `tbl_cnt` at entry `tbl_idx`. Entry index is the rank, and a rewrite replaces the old address at that rank.
- R2: `vic_lock` is 1 exactly when the fill address equals a kept entry whose index is below LOCK_N and a victim exists. LOCK_N is ENTRIES*LOCK_PCT/100, which is 4 with the defaults. If several kept entries match, the lowest index counts.
- R3: If any way has `way_valid`=0, the victim is the lowest-numbered invalid way, whatever the lock bits and table contents.
- R4: When every way is valid, a way with `way_lock`=1 is never returned as victim.
- R5: When every way is valid, an unlocked way whose address matches no kept entry is chosen ahead of every unlocked way whose address matches one.
- R6: Among unlocked valid ways whose addresses are all in the table, the one with the smallest miss count is chosen.
- R7: Ties are resolved by a 16-bit register that resets to 16'hACE1 and advances on every clock as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. With n tied ways, the value s present in the request cycle selects the (s mod n)-th tied way, counted from the lowest way number starting at 0. Ways absent from the table all tie with each other.
- R8: If every way is valid and locked, the response has `vic_none`=1, `vic_way`=0 and `vic_lock`=0.
- R9: A request sampled on a rising edge gives `vic_valid`=1 with its result from that edge until the next. In a cycle after no request, all four outputs are 0.
- R10: After reset every output is 0 and every table entry is empty, so every address counts as absent.
- R11: Writing an entry with `tbl_keep`=0 removes it, so its address is then treated as absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W (4) | Entry index, which is also its rank |
| tbl_keep | input | 1 | 1 stores the entry, 0 empties it |
| tbl_addr | input | ADDR_W (16) | Profiled block address |
| tbl_cnt | input | CNT_W (8) | Profiled miss count |
| fill_req | input | 1 | Fill request, one cycle |
| fill_addr | input | ADDR_W (16) | Address of the incoming block |
| way_valid | input | WAYS (4) | Per-way valid bit |
| way_lock | input | WAYS (4) | Per-way lock bit |
| way_addr | input | WAYS*ADDR_W (64) | Per-way block address, way 0 in the low bits |
| vic_valid | output | 1 | Result valid, one cycle after a request |
| vic_way | output | WAY_W (2) | Way to evict |
| vic_none | output | 1 | Every way is pinned, do not cache |
| vic_lock | output | 1 | Pin the incoming block |

## Verification
All four outputs are registered once, so a result is due exactly one rising edge after the request is sampled. The bench drives every request on a falling edge and reads the outputs on the next falling edge. It also reads them one more cycle later to confirm they return to zero. The tie-breaking register only advances with the clock, so the bench keeps its own copy of it, stepped on the same edges from the same reset. The value it uses for a tie is the one present when the request is driven.

// File: rtl/lvs_pkg.sv
package lvs_pkg;

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic int unsigned pop32(input logic [31:0] m);
    int unsigned n = 0;
    for (int i = 0; i < 32; i++) n += 32'(m[i]);
    return n;
  endfunction

  // index of the k-th set bit, counting from bit 0
  function automatic int unsigned pick_kth(input logic [31:0] m, input int unsigned k);
    int unsigned seen = 0;
    int unsigned pick = 0;
    bit found = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (m[i] && !found) begin
        if (seen == k) begin
          pick  = i;
          found = 1'b1;
        end
        seen++;
      end
    end
    return pick;
  endfunction

endpackage

// File: rtl/lvs_store.sv
module lvs_store #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic                             wr_keep,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [CNT_W-1:0]                 wr_cnt,
  output logic [ENTRIES-1:0]               ent_vld,
  output logic [ENTRIES-1:0][ADDR_W-1:0]   ent_addr,
  output logic [ENTRIES-1:0][CNT_W-1:0]    ent_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_addr <= '0;
      ent_cnt  <= '0;
    end else if (wr_en && (int'(wr_idx) < ENTRIES)) begin
      ent_vld[wr_idx]  <= wr_keep;
      ent_addr[wr_idx] <= wr_addr;
      ent_cnt[wr_idx]  <= wr_cnt;
    end
  end
endmodule

// File: rtl/lvs_match.sv
module lvs_match #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 16,
  parameter int VAL_W   = 8
) (
  input  logic [ENTRIES-1:0]             ent_vld,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
  input  logic [ENTRIES-1:0][VAL_W-1:0]  payload,
  input  logic [ADDR_W-1:0]              key,
  output logic                           hit,
  output logic [VAL_W-1:0]               val
);
  logic [ENTRIES-1:0] eq;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign eq[e] = ent_vld[e] && (ent_addr[e] == key);
  end

  // lowest matching entry wins
  always_comb begin
    hit = |eq;
    val = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (eq[e]) val = payload[e];
    end
  end
endmodule

// File: rtl/lvs_lfsr.sv
module lvs_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state
);
  import lvs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= lfsr_step(state);
  end

  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    state != 16'h0000);
endmodule

// File: rtl/lvs_arb.sv
module lvs_arb #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 8,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0]             lock,
  input  logic [WAYS-1:0]             present,
  input  logic [WAYS-1:0][CNT_W-1:0]  cnt,
  input  logic [15:0]                 rnd,
  output logic [WAY_W-1:0]            sel_way,
  output logic                        none
);
  import lvs_pkg::*;

  localparam int KEY_W = CNT_W + 1;

  logic [KEY_W-1:0] key [WAYS];
  logic [KEY_W-1:0] kmin;
  logic [WAYS-1:0]  cand;
  logic [WAYS-1:0]  tie;
  logic [WAY_W-1:0] first_inv;
  int unsigned      ntie;

  // absent addresses rank as key 0, present ones as count + 1
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      key[w] = present[w] ? ({1'b0, cnt[w]} + KEY_W'(1)) : '0;
    end
    cand = ~lock;
    kmin = '1;
    for (int w = 0; w < WAYS; w++) begin
      if (cand[w] && (key[w] < kmin)) kmin = key[w];
    end
    for (int w = 0; w < WAYS; w++) begin
      tie[w] = cand[w] && (key[w] == kmin);
    end
    ntie = pop32(32'(tie));
    first_inv = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) first_inv = WAY_W'(w);
    end
  end

  always_comb begin
    none    = 1'b0;
    sel_way = '0;
    if (!(&valid)) begin
      sel_way = first_inv;
    end else if (cand == '0) begin
      none = 1'b1;
    end else begin
      sel_way = WAY_W'(pick_kth(32'(tie), 32'(rnd) % ((ntie == 0) ? 1 : ntie)));
    end
  end
endmodule

// File: rtl/l2_victim_pick.sv
module l2_victim_pick #(
  parameter int ENTRIES  = 16,
  parameter int WAYS     = 4,
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 8,
  parameter int LOCK_PCT = 25,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_we,
  input  logic [IDX_W-1:0]         tbl_idx,
  input  logic                     tbl_keep,
  input  logic [ADDR_W-1:0]        tbl_addr,
  input  logic [CNT_W-1:0]         tbl_cnt,
  input  logic                     fill_req,
  input  logic [ADDR_W-1:0]        fill_addr,
  input  logic [WAYS-1:0]          way_valid,
  input  logic [WAYS-1:0]          way_lock,
  input  logic [WAYS*ADDR_W-1:0]   way_addr,
  output logic                     vic_valid,
  output logic [WAY_W-1:0]         vic_way,
  output logic                     vic_none,
  output logic                     vic_lock
);
  localparam int LOCK_N = (ENTRIES * LOCK_PCT) / 100;

  logic [ENTRIES-1:0]             ent_vld;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [ENTRIES-1:0][CNT_W-1:0]  ent_cnt;
  logic [ENTRIES-1:0][IDX_W-1:0]  rank_tab;
  logic [WAYS-1:0]                way_hit;
  logic [WAYS-1:0][CNT_W-1:0]     way_cnt;
  logic                           fill_hit;
  logic [IDX_W-1:0]               fill_rank;
  logic [15:0]                    rnd;
  logic [WAY_W-1:0]               sel_way;
  logic                           sel_none;
  logic                           lock_c;

  lvs_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_store (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_keep(tbl_keep),
    .wr_addr(tbl_addr), .wr_cnt(tbl_cnt),
    .ent_vld(ent_vld), .ent_addr(ent_addr), .ent_cnt(ent_cnt)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_rank
    assign rank_tab[e] = IDX_W'(e);
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    lvs_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .VAL_W(CNT_W)) i_way_match (
      .ent_vld(ent_vld), .ent_addr(ent_addr), .payload(ent_cnt),
      .key(way_addr[w*ADDR_W +: ADDR_W]), .hit(way_hit[w]), .val(way_cnt[w])
    );
  end

  lvs_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .VAL_W(IDX_W)) i_fill_match (
    .ent_vld(ent_vld), .ent_addr(ent_addr), .payload(rank_tab),
    .key(fill_addr), .hit(fill_hit), .val(fill_rank)
  );

  lvs_lfsr #(.SEED(SEED)) i_lfsr (.clk(clk), .rst_n(rst_n), .state(rnd));

  lvs_arb #(.WAYS(WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)) i_arb (
    .valid(way_valid), .lock(way_lock), .present(way_hit), .cnt(way_cnt),
    .rnd(rnd), .sel_way(sel_way), .none(sel_none)
  );

  assign lock_c = fill_hit && (int'(fill_rank) < LOCK_N) && !sel_none;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vic_valid <= 1'b0;
      vic_way   <= '0;
      vic_none  <= 1'b0;
      vic_lock  <= 1'b0;
    end else begin
      vic_valid <= fill_req;
      vic_way   <= fill_req ? sel_way  : '0;
      vic_none  <= fill_req && sel_none;
      vic_lock  <= fill_req && lock_c;
    end
  end

  a_r9_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> vic_valid);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_req |=> (!vic_valid && !vic_lock && !vic_none));
  a_r3_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !(&way_valid)) |-> !way_valid[sel_way]);
  a_r4_never_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && (&way_valid) && !sel_none) |-> !way_lock[sel_way]);
  a_r8_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && (&way_valid) && (&way_lock)) |=> (vic_none && !vic_lock));
  a_r2_lock_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    vic_lock |-> $past(fill_hit));
endmodule

// File: tb/test_l2_victim_pick.sv
`timescale 1ns/1ps
module test_l2_victim_pick;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic        tbl_keep = 1'b0;
  logic [15:0] tbl_addr = '0;
  logic [7:0]  tbl_cnt = '0;
  logic        fill_req = 1'b0;
  logic [15:0] fill_addr = '0;
  logic [3:0]  way_valid = '0;
  logic [3:0]  way_lock = '0;
  logic [15:0] wa [4];
  logic [63:0] way_addr;
  logic        vic_valid, vic_none, vic_lock;
  logic [1:0]  vic_way;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  bit          tv [16];
  logic [15:0] ta [16];
  logic [7:0]  tc [16];
  logic [15:0] m_lfsr;

  assign way_addr = {wa[3], wa[2], wa[1], wa[0]};

  always #10 clk = ~clk;

  l2_victim_pick i_l2_victim_pick (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_keep(tbl_keep),
    .tbl_addr(tbl_addr), .tbl_cnt(tbl_cnt), .fill_req(fill_req), .fill_addr(fill_addr),
    .way_valid(way_valid), .way_lock(way_lock), .way_addr(way_addr),
    .vic_valid(vic_valid), .vic_way(vic_way), .vic_none(vic_none), .vic_lock(vic_lock)
  );

  // R7 tie register model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int find_rank(input logic [15:0] a);
    for (int e = 0; e < 16; e++) if (tv[e] && ta[e] == a) return e;
    return -1;
  endfunction

  function automatic void predict(input logic [15:0] faddr, input logic [15:0] rnd,
                                  output int ew, output bit en, output bit el);
    int mc [4];
    int tl [4];
    int nt = 0;
    int best = 1000;
    int r;
    ew = 0; en = 1'b0;
    if (way_valid != 4'hF) begin
      for (int w = 3; w >= 0; w--) if (!way_valid[w]) ew = w;
    end else begin
      for (int w = 0; w < 4; w++) begin
        r = find_rank(wa[w]);
        mc[w] = (r < 0) ? -1 : int'(tc[r]);
        if (!way_lock[w] && mc[w] < best) best = mc[w];
      end
      for (int w = 0; w < 4; w++) if (!way_lock[w] && mc[w] == best) begin
        tl[nt] = w; nt++;
      end
      if (nt == 0) en = 1'b1;
      else ew = tl[int'(rnd) % nt];
    end
    r = find_rank(faddr);
    el = (r >= 0) && (r < 4) && !en;
  endfunction

  task automatic load(input int i, input bit keep, input logic [15:0] a, input logic [7:0] c);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 4'(i); tbl_keep = keep; tbl_addr = a; tbl_cnt = c;
    @(negedge clk);
    tbl_we = 1'b0;
    tv[i] = keep; ta[i] = a; tc[i] = c;
  endtask

  task automatic set_ways(input logic [3:0] v, input logic [3:0] l,
                          input logic [15:0] a0, input logic [15:0] a1,
                          input logic [15:0] a2, input logic [15:0] a3);
    way_valid = v; way_lock = l;
    wa[0] = a0; wa[1] = a1; wa[2] = a2; wa[3] = a3;
  endtask

  task automatic fill(input string tag, input logic [15:0] a);
    int ew; bit en; bit el;
    @(negedge clk);
    fill_addr = a;
    predict(a, m_lfsr, ew, en, el);
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    check({tag, " valid"}, int'(vic_valid), 1);
    check({tag, " way"},   int'(vic_way), ew);
    check({tag, " none"},  int'(vic_none), int'(en));
    check({tag, " lock"},  int'(vic_lock), int'(el));
  endtask

  function automatic logic [15:0] rnd_addr();
    if (($urandom % 4) != 0) return ta[$urandom % 16];
    return 16'h8000 | 16'($urandom % 4096);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int e = 0; e < 16; e++) begin tv[e] = 0; ta[e] = '0; tc[e] = '0; end
    for (int w = 0; w < 4; w++) wa[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset valid", int'(vic_valid), 0);
    check("R10 reset way",   int'(vic_way), 0);
    check("R10 reset none",  int'(vic_none), 0);
    check("R10 reset lock",  int'(vic_lock), 0);
    set_ways(4'hF, 4'h0, 16'h1000, 16'h1010, 16'h1020, 16'h1030);
    fill("R10 empty table tie R7", 16'h1000);

    for (int i = 0; i < 16; i++) load(i, 1'b1, 16'h1000 + 16'(i * 16), 8'(200 - 10 * i));

    set_ways(4'hF, 4'h0, 16'h1020, 16'h1050, 16'h1070, 16'h1090);
    fill("R6 min count", 16'h1400);
    set_ways(4'hF, 4'h0, 16'h1020, 16'h9999, 16'h1070, 16'h1090);
    fill("R5 absent first", 16'h1000);
    set_ways(4'hB, 4'hF, 16'h1020, 16'h1050, 16'h1070, 16'h1090);
    fill("R3 invalid way", 16'h1010);
    set_ways(4'h5, 4'h0, 16'h1020, 16'h1050, 16'h1070, 16'h1090);
    fill("R3 lowest invalid", 16'h1030);
    set_ways(4'hF, 4'hF, 16'h1020, 16'h1050, 16'h1070, 16'h1090);
    fill("R8 all locked", 16'h1000);
    set_ways(4'hF, 4'h8, 16'h1010, 16'h1020, 16'h1030, 16'h10F0);
    fill("R4 locked skipped", 16'h1030);
    fill("R2 rank3 locks", 16'h1030);
    fill("R2 rank4 no lock", 16'h1040);
    fill("R2 absent no lock", 16'h7777);
    set_ways(4'hF, 4'h0, 16'h1020, 16'h9001, 16'h9002, 16'h9003);
    fill("R7 absent tie", 16'h1000);
    fill("R7 absent tie again", 16'h1000);
    load(5, 1'b0, 16'h1050, 8'd150);
    set_ways(4'hF, 4'h0, 16'h1020, 16'h1050, 16'h1070, 16'h1090);
    fill("R11 cleared entry", 16'h1050);
    load(0, 1'b1, 16'h5A5A, 8'd250);
    fill("R1 rewritten rank0", 16'h5A5A);
    fill("R1 old rank0 gone", 16'h1000);
    @(negedge clk);
    check("R9 idle valid", int'(vic_valid), 0);
    check("R9 idle lock", int'(vic_lock), 0);

    for (int i = 0; i < 16; i++) load(i, 1'b1, 16'h2000 + 16'(i * 4), 8'(60 - (i / 3) * 5));
    for (int n = 0; n < 400; n++) begin
      logic [3:0] v, l;
      for (int w = 0; w < 4; w++) begin
        v[w] = (($urandom % 8) != 0);
        l[w] = (($urandom % 4) == 0);
      end
      set_ways(v, l, rnd_addr(), rnd_addr(), rnd_addr(), rnd_addr());
      fill("R6 R7 random", rnd_addr());
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule